// File: doc/BRIEF.md
# Binary Shape Context Generator

This block feeds a context-adaptive binary arithmetic coder that codes 16x16 binary shape blocks. For every pixel, taken in raster order, it delivers in one clock cycle the context index that selects a probability entry and the pixel value to be coded. A caller loads one row position at a time: a single strobe carries every row the templates need for that line, each padded with two border columns on either side. The block masks the row, stores it in a small two-dimensional bit array, and then shifts every row of the array left by one bit per cycle, so that fixed taps near the left edge always see the neighbourhood of the current pixel.

One array serves both coding modes. In intra mode the upper three array rows hold the current block (two rows above the coded line and the coded line itself), and a 10-bit context is formed. In inter mode the upper two rows hold the current block (the line above and the coded line) and the lower three hold the motion-compensated block (the line above, the co-located line and the line below), and a 9-bit context is formed. With border use turned off, every template position that falls outside the block reads as 0. This is the usual case for a block with no coded neighbours.

Top module: `cgen_ctx_gen`

## Requirements
- R1: While `rst` is high, on the cycle after it, and whenever `vld_o` is low, `vld_o`, `ctx_o` and `bit_o` are all 0.
- R2: A load that is accepted at a clock edge makes `vld_o` high from that edge for exactly 16 consecutive cycles. The k-th valid cycle (k = 0..15) presents pixel column k of the loaded line.
- R3: `rows_i` carries five 20-bit row words; row r sits at bits [r*20 +: 20], and inside a word bit 19-(c+2) holds column c for c = -2..17. In intra mode rows 0,1,2 are the current block at lines y-2, y-1, y. In inter mode rows 0,1 are the current block at lines y-1, y and rows 2,3,4 are the motion-compensated block at lines y-1, y, y+1.
- R4: Intra context, bit 0 upward: cur(y,x-1), cur(y,x-2), cur(y-1,x+2), cur(y-1,x+1), cur(y-1,x), cur(y-1,x-1), cur(y-1,x-2), cur(y-2,x+1), cur(y-2,x), cur(y-2,x-1).
- R5: Inter context, bit 0 upward: cur(y,x-1), cur(y-1,x+1), cur(y-1,x), cur(y-1,x-1), mc(y,x+1), mc(y,x), mc(y,x-1), mc(y-1,x), mc(y+1,x). Bit 9 is 0.
- R6: `bit_o` is cur(y,x), the pixel being coded.
- R7: With `border_en_i` low at the load, columns outside 0..15 read as 0.
- R8: With `border_en_i` low at the load, lines outside 0..15 read as 0. The line index y is 0 for a load with `blk_start_i` high (and after reset), and otherwise one more than the previous accepted load, modulo 16.
- R9: With `border_en_i` high at the load, every supplied bit, pad columns and out-of-block lines included, is used as given.
- R10: A load is accepted when the block is idle or on the last valid cycle of a line, which gives back-to-back lines with no gap. A load on any other valid cycle is ignored: it does not change the outputs or the line index.
- R11: Mode and border use are sampled only at the accepted load and hold for that line. In intra mode rows 3 and 4 of `rows_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_i | input | 1 | Line load strobe |
| blk_start_i | input | 1 | With a load: this line is line 0 of a new block |
| mode_i | input | 1 | 0 = intra, 1 = inter |
| border_en_i | input | 1 | 1 = use supplied bits outside the block, 0 = force them to 0 |
| rows_i | input | 100 | Five padded row words, layout in R3 |
| ctx_o | output | 10 | Context index |
| bit_o | output | 1 | Pixel to be coded |
| vld_o | output | 1 | Context and bit are valid |

## Verification
A line loaded at clock edge N produces pixel 0 in the cycle that starts at edge N, and pixel k in the cycle after edge N+k. No register sits between the array taps and the outputs. The bench drives each load half a cycle before edge N and samples at the falling edge of each of the 16 following cycles. It compares every context and bit against a software model of both templates, computed from random padded canvases. In gap mode it checks one idle cycle, and in back-to-back mode it raises the next load in the same falling-edge slot as the sample for pixel 15. Right after every load it changes mode, border use and the row words, and during some lines it injects a mid-line load. Any of these that leaked into the line would show up in the following samples.

// File: rtl/cgen_pkg.sv
package cgen_pkg;

    localparam int unsigned BLK_W  = 16;
    localparam int unsigned PAD    = 2;
    localparam int unsigned ROWS   = 5;
    localparam int unsigned WORD_W = BLK_W + 2 * PAD;
    localparam int unsigned CTX_W  = 10;
    localparam int unsigned IDX_W  = $clog2(BLK_W);
    localparam int unsigned INTRA_ROWS = 3;

    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(BLK_W - 1);
    // columns 0..BLK_W-1 kept, pad columns cleared
    localparam logic [WORD_W-1:0] COL_KEEP = {{PAD{1'b0}}, {BLK_W{1'b1}}, {PAD{1'b0}}};

    typedef enum logic {
        MODE_INTRA = 1'b0,
        MODE_INTER = 1'b1
    } cmode_e;

    typedef logic [WORD_W-1:0] rowword_t;

    // five-pixel horizontal neighbourhood of the current column
    typedef struct packed {
        logic m2;
        logic m1;
        logic z0;
        logic p1;
        logic p2;
    } win_t;

    // tap for offset d sits at WORD_W-1-PAD-d regardless of shift count
    function automatic win_t tap_win(rowword_t r);
        win_t w;
        w.m2 = r[WORD_W + 1 - PAD];
        w.m1 = r[WORD_W     - PAD];
        w.z0 = r[WORD_W - 1 - PAD];
        w.p1 = r[WORD_W - 2 - PAD];
        w.p2 = r[WORD_W - 3 - PAD];
        return w;
    endfunction

    function automatic logic row_used(cmode_e m, int r);
        return (m == MODE_INTER) ? (r < int'(ROWS)) : (r < int'(INTRA_ROWS));
    endfunction

    // vertical offset of array row r relative to the coded line
    function automatic int row_dy(cmode_e m, int r);
        if (m == MODE_INTRA) return r - 2;
        return (r < 2) ? (r - 1) : (r - 3);
    endfunction

    function automatic logic row_outside(cmode_e m, int r, logic [IDX_W-1:0] y);
        int yy;
        yy = int'(y) + row_dy(m, r);
        return (yy < 0) || (yy > int'(BLK_W) - 1);
    endfunction

    // a: line y-2, b: line y-1, c: line y
    function automatic logic [CTX_W-1:0] intra_ctx(win_t a, win_t b, win_t c);
        return {a.m1, a.z0, a.p1, b.m2, b.m1, b.z0, b.p1, b.p2, c.m2, c.m1};
    endfunction

    // cu/cc: current lines y-1/y; mu/mm/md: compensated lines y-1/y/y+1
    function automatic logic [CTX_W-1:0] inter_ctx(win_t cu, win_t cc, win_t mu,
                                                   win_t mm, win_t md);
        return {1'b0, md.z0, mu.z0, mm.m1, mm.z0, mm.p1, cu.m1, cu.z0, cu.p1, cc.m1};
    endfunction

endpackage

// File: rtl/cgen_rowctl.sv
module cgen_rowctl
    import cgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ld_i,
    input  logic             blk_start_i,
    input  cmode_e           mode_i,
    input  logic             border_i,
    output logic             accept_o,
    output logic             busy_o,
    output logic [IDX_W-1:0] load_y_o,
    output cmode_e           mode_o
);

    logic             busy_q;
    logic [IDX_W-1:0] col_q;
    logic [IDX_W-1:0] nxt_y_q;
    cmode_e           mode_q;
    logic             border_q;

    assign accept_o = ld_i && (!busy_q || col_q == LAST_IDX);
    assign load_y_o = blk_start_i ? '0 : nxt_y_q;
    assign busy_o   = busy_q;
    assign mode_o   = mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            col_q    <= '0;
            nxt_y_q  <= '0;
            mode_q   <= MODE_INTRA;
            border_q <= 1'b0;
        end else if (accept_o) begin
            busy_q   <= 1'b1;
            col_q    <= '0;
            nxt_y_q  <= load_y_o + 1'b1;
            mode_q   <= mode_i;
            border_q <= border_i;
        end else if (busy_q) begin
            col_q <= col_q + 1'b1;
            if (col_q == LAST_IDX) busy_q <= 1'b0;
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !busy_q);

    // R2
    run_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q && col_q != LAST_IDX |=> busy_q);

    // R2
    line_end_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q && col_q == LAST_IDX && !ld_i |=> !busy_q);

    // R10
    mid_load_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q && col_q != LAST_IDX && ld_i |=> col_q == $past(col_q) + 1'b1);

    // R11
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy_q && col_q != LAST_IDX |=> $stable(mode_q) && $stable(border_q));

endmodule

// File: rtl/cgen_loadmask.sv
module cgen_loadmask
    import cgen_pkg::*;
(
    input  rowword_t         raw_i [ROWS],
    input  cmode_e           mode_i,
    input  logic             border_i,
    input  logic [IDX_W-1:0] load_y_i,
    output rowword_t         row_o [ROWS]
);

    always_comb begin
        for (int r = 0; r < int'(ROWS); r++) begin
            if (!row_used(mode_i, r)) begin
                row_o[r] = '0;
            end else if (border_i) begin
                row_o[r] = raw_i[r];
            end else if (row_outside(mode_i, r, load_y_i)) begin
                row_o[r] = '0;
            end else begin
                row_o[r] = raw_i[r] & COL_KEEP;
            end
        end
    end

    // R7
    pad_clear_chk: assert final (border_i || ((row_o[0] | row_o[1] | row_o[2]
                                 | row_o[3] | row_o[4]) & ~COL_KEEP) == '0);

endmodule

// File: rtl/cgen_shiftarray.sv
module cgen_shiftarray
    import cgen_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     accept_i,
    input  logic     busy_i,
    input  rowword_t load_i [ROWS],
    output win_t     win_o  [ROWS]
);

    rowword_t rows_q [ROWS];

    always_ff @(posedge clk) begin
        for (int r = 0; r < int'(ROWS); r++) begin
            if (rst) begin
                rows_q[r] <= '0;
            end else if (accept_i) begin
                rows_q[r] <= load_i[r];
            end else if (busy_i) begin
                rows_q[r] <= rows_q[r] << 1;
            end
        end
    end

    for (genvar gi = 0; gi < int'(ROWS); gi++) begin : g_row
        assign win_o[gi] = tap_win(rows_q[gi]);

        // R2
        shift_step_chk: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) && $past(busy_i) && !$past(accept_i)
            |-> rows_q[gi][WORD_W-1:1] == $past(rows_q[gi][WORD_W-2:0]));
    end

endmodule

// File: rtl/cgen_taps.sv
module cgen_taps
    import cgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  win_t             win_i [ROWS],
    input  cmode_e           mode_i,
    input  logic             busy_i,
    output logic [CTX_W-1:0] ctx_o,
    output logic             bit_o
);

    logic [CTX_W-1:0] ctx_intra;
    logic [CTX_W-1:0] ctx_inter;

    assign ctx_intra = intra_ctx(win_i[0], win_i[1], win_i[2]);
    assign ctx_inter = inter_ctx(win_i[0], win_i[1], win_i[2], win_i[3], win_i[4]);

    always_comb begin
        ctx_o = '0;
        bit_o = 1'b0;
        if (busy_i) begin
            if (mode_i == MODE_INTRA) begin
                ctx_o = ctx_intra;
                bit_o = win_i[2].z0;
            end else begin
                ctx_o = ctx_inter;
                bit_o = win_i[1].z0;
            end
        end
    end

    // R5
    inter_top_zero_chk: assert property (@(posedge clk) disable iff (rst)
        busy_i && mode_i == MODE_INTER |-> !ctx_o[CTX_W-1]);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy_i |-> ctx_o == '0 && !bit_o);

endmodule

// File: rtl/cgen_ctx_gen.sv
module cgen_ctx_gen
    import cgen_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ld_i,
    input  logic                    blk_start_i,
    input  logic                    mode_i,
    input  logic                    border_en_i,
    input  logic [ROWS*WORD_W-1:0]  rows_i,
    output logic [CTX_W-1:0]        ctx_o,
    output logic                    bit_o,
    output logic                    vld_o
);

    cmode_e           mode_in;
    cmode_e           mode_q;
    logic             accept;
    logic             busy;
    logic [IDX_W-1:0] load_y;
    rowword_t         raw   [ROWS];
    rowword_t         mask  [ROWS];
    win_t             win   [ROWS];

    assign mode_in = cmode_e'(mode_i);

    for (genvar gi = 0; gi < int'(ROWS); gi++) begin : g_split
        assign raw[gi] = rows_i[gi*WORD_W +: WORD_W];
    end

    cgen_rowctl u_ctl (
        .clk         (clk),
        .rst         (rst),
        .ld_i        (ld_i),
        .blk_start_i (blk_start_i),
        .mode_i      (mode_in),
        .border_i    (border_en_i),
        .accept_o    (accept),
        .busy_o      (busy),
        .load_y_o    (load_y),
        .mode_o      (mode_q)
    );

    cgen_loadmask u_mask (
        .raw_i    (raw),
        .mode_i   (mode_in),
        .border_i (border_en_i),
        .load_y_i (load_y),
        .row_o    (mask)
    );

    cgen_shiftarray u_arr (
        .clk      (clk),
        .rst      (rst),
        .accept_i (accept),
        .busy_i   (busy),
        .load_i   (mask),
        .win_o    (win)
    );

    cgen_taps u_taps (
        .clk    (clk),
        .rst    (rst),
        .win_i  (win),
        .mode_i (mode_q),
        .busy_i (busy),
        .ctx_o  (ctx_o),
        .bit_o  (bit_o)
    );

    assign vld_o = busy;

    // R10
    b2b_chk: assert property (@(posedge clk) disable iff (rst)
        accept |=> vld_o);

endmodule

// File: tb/tb_cgen_ctx_gen.sv
`timescale 1ns/1ps
module tb_cgen_ctx_gen;

    localparam int W  = 20;
    localparam int NR = 5;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            ld = 1'b0;
    logic            blk_start = 1'b0;
    logic            mode = 1'b0;
    logic            border_en = 1'b0;
    logic [NR*W-1:0] rows = '0;
    logic [9:0]      ctx;
    logic            bitv;
    logic            vld;

    int n_vec = 0;
    int n_bad = 0;

    bit cv_cur [20][20];
    bit cv_mc  [20][20];

    always #2 clk = ~clk;

    cgen_ctx_gen dut (
        .clk(clk), .rst(rst), .ld_i(ld), .blk_start_i(blk_start),
        .mode_i(mode), .border_en_i(border_en), .rows_i(rows),
        .ctx_o(ctx), .bit_o(bitv), .vld_o(vld)
    );

    task automatic chk(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int px(bit mc, bit b, int yy, int xx);
        if (!b && (yy < 0 || yy > 15 || xx < 0 || xx > 15)) return 0;
        return mc ? int'(cv_mc[yy+2][xx+2]) : int'(cv_cur[yy+2][xx+2]);
    endfunction

    // R4 / R5 templates
    function automatic int exp_ctx(bit m, bit b, int y, int x);
        if (!m)
            return px(0,b,y,x-1) | px(0,b,y,x-2)<<1 | px(0,b,y-1,x+2)<<2
                 | px(0,b,y-1,x+1)<<3 | px(0,b,y-1,x)<<4 | px(0,b,y-1,x-1)<<5
                 | px(0,b,y-1,x-2)<<6 | px(0,b,y-2,x+1)<<7 | px(0,b,y-2,x)<<8
                 | px(0,b,y-2,x-1)<<9;
        return px(0,b,y,x-1) | px(0,b,y-1,x+1)<<1 | px(0,b,y-1,x)<<2
             | px(0,b,y-1,x-1)<<3 | px(1,b,y,x+1)<<4 | px(1,b,y,x)<<5
             | px(1,b,y,x-1)<<6 | px(1,b,y-1,x)<<7 | px(1,b,y+1,x)<<8;
    endfunction

    // R3 layout, canvas bits given unmasked
    function automatic logic [W-1:0] row_word(bit mc, int yy);
        logic [W-1:0] w;
        for (int c = -2; c < 18; c++)
            w[W-1-(c+2)] = mc ? cv_mc[yy+2][c+2] : cv_cur[yy+2][c+2];
        return w;
    endfunction

    function automatic logic [NR*W-1:0] build_rows(bit m, int y);
        logic [NR*W-1:0] v;
        for (int r = 0; r < NR; r++) begin
            if (!m && r >= 3) v[r*W +: W] = W'($urandom);          // R11 junk
            else if (!m)      v[r*W +: W] = row_word(0, y + r - 2);
            else if (r < 2)   v[r*W +: W] = row_word(0, y + r - 1);
            else              v[r*W +: W] = row_word(1, y + r - 3);
        end
        return v;
    endfunction

    function automatic logic [NR*W-1:0] junk();
        logic [NR*W-1:0] v;
        for (int r = 0; r < NR; r++) v[r*W +: W] = W'($urandom);
        return v;
    endfunction

    task automatic fill_canvas();
        for (int i = 0; i < 20; i++)
            for (int j = 0; j < 20; j++) begin
                cv_cur[i][j] = 1'($urandom);
                cv_mc[i][j]  = 1'($urandom);
            end
    endtask

    // called at a falling edge; returns at the falling edge of pixel 15
    task automatic apply_row(int y, bit m, bit b, bit inject);
        string tag;
        tag = $sformatf("%s %s R3 R11 y=%0d", m ? "R5" : "R4",
                        b ? "R9" : "R7 R8", y);
        ld = 1'b1; blk_start = (y == 0); mode = m; border_en = b;
        rows = build_rows(m, y);
        @(negedge clk);
        ld = 1'b0; blk_start = 1'b0; mode = ~m; border_en = ~b; rows = junk();
        for (int k = 0; k < 16; k++) begin
            chk("R2 valid", int'(vld), 1);
            chk({tag, inject ? " R10" : ""}, int'(ctx), exp_ctx(m, b, y, k));
            chk("R6 bit", int'(bitv), px(0, b, y, k));
            if (inject && k == 5) begin
                ld = 1'b1; blk_start = 1'b1; rows = junk();  // R10 ignored load
            end else begin
                ld = 1'b0; blk_start = 1'b0;
            end
            if (k < 15) @(negedge clk);
        end
    endtask

    task automatic run_block(bit m, bit b, bit gap, bit inject);
        fill_canvas();
        for (int y = 0; y < 16; y++) begin
            apply_row(y, m, b, inject && (y % 4 == 1));
            if (gap) begin
                @(negedge clk);
                chk("R10 R1 idle valid", int'(vld), 0);
                chk("R1 idle ctx", int'(ctx), 0);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset valid", int'(vld), 0);
        chk("R1 reset ctx", int'(ctx), 0);
        chk("R1 reset bit", int'(bitv), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 post-reset valid", int'(vld), 0);
        for (int s = 0; s < 2; s++) begin
            run_block(1'b0, 1'b0, 1'b0, 1'b0);
            run_block(1'b1, 1'b0, 1'b1, 1'b0);
            run_block(1'b0, 1'b1, 1'b1, 1'b1);
            run_block(1'b1, 1'b1, 1'b0, 1'b1);
        end
        // reset in the middle of a line
        fill_canvas();
        ld = 1'b1; blk_start = 1'b1; mode = 1'b1; border_en = 1'b1;
        rows = build_rows(1'b1, 0);
        @(negedge clk);
        ld = 1'b0; blk_start = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-line reset valid", int'(vld), 0);
        chk("R1 mid-line reset ctx", int'(ctx), 0);
        chk("R1 mid-line reset bit", int'(bitv), 0);
        rst = 1'b0;
        @(negedge clk);
        run_block(1'b1, 1'b0, 1'b0, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule